// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software through a 12-bit down-counter that is advanced by a divided tick. Software must service it on a regular schedule. If the count runs past zero before a service arrives, the block raises a reset request. It also raises one if software services it too soon, while the count is still above a programmed window threshold. The result is a bounded window of legal service times, not just a deadline.

Configuration goes through a small register port with separate write and read strobes. The configuration covers the reload value, the window threshold, the tick divider, the enable and the debug-stop option. A key register guards the configuration: it opens for writes only after a fixed 16-bit key is written, and any other value written there closes it again. Once enabled, the watchdog keeps running until the next reset. A debug-halt input can freeze counting when debug-stop is set. A sticky status register records why the last reset request fired. It clears when it is read.

Register map: address 0 holds the reload value, 1 the window threshold, 2 the control register, 3 the key/lock register, 4 the service register, 5 the status register and 6 the current count (read-only). Control bits: bit 0 is enable, bit 1 is debug-stop, and bits [4:2] hold the divider select n. The port carries no data stream, so it has no valid/ready handshake. Every strobe takes effect in the cycle it is sampled.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `rst_req` is 0, the lock reads 1 at address 3, reload and threshold both read 0xFFF, control reads 0 and status reads 0.
- R2: While enabled, the count decrements by one on each tick. A tick occurs once every 2^n clocks, where n is control bits [4:2]. Both the count and the divider restart on a service or while the watchdog is disabled.
- R3: A tick that finds the count at 0 with no service in the same cycle pulses `rst_req` high for the next clock. It also sets status bit 0 and reloads the count. With reload R and select n, this happens on the ((R+1)·2^n)-th edge after the enabling or servicing edge.
- R4: Writing 1 to bit 0 at address 4 while the count is above the threshold pulses `rst_req` on the next clock. It also sets status bit 1 and reloads the count.
- R5: A service while the count is at or below the threshold (equality included) raises no request. The count then equals the reload value on the next clock.
- R6: While `dbg_halt` is 1 and debug-stop is set, the count holds and no underflow request occurs.
- R7: While locked, writes to addresses 0, 1 and 2 are ignored. Writing 0x3C96 to address 3 unlocks the registers. Any other value written there locks them.
- R8: Once enable is set it stays set: a control write with bit 0 cleared leaves it at 1, and counting continues.
- R9: Reading address 5 returns the status and clears it. A new cause in the same cycle as the read is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (clears status when address 5) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data for `rd_addr` |
| dbg_halt | input | 1 | Debugger halt indication |
| rst_req | output | 1 | Registered reset request pulse |

## Verification
The assertions assume that a write and a read never target the status register in conflicting ways. They also assume that the service command and a configuration write never occur in the same cycle, which follows from the single write port. They further assume that `dbg_halt` and the strobes change only between clock edges. The bench drives every input on the falling edge, issues one write at a time, and services the running watchdog often enough that no unplanned underflow lands inside a measured window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam logic [AW-1:0] A_RELOAD = 3'd0;
  localparam logic [AW-1:0] A_DELTA  = 3'd1;
  localparam logic [AW-1:0] A_CTRL   = 3'd2;
  localparam logic [AW-1:0] A_KEY    = 3'd3;
  localparam logic [AW-1:0] A_SVC    = 3'd4;
  localparam logic [AW-1:0] A_STAT   = 3'd5;
  localparam logic [AW-1:0] A_COUNT  = 3'd6;
  typedef struct packed {
    logic early;
    logic uflow;
  } cause_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW = (1 << SEL_W) - 1;
  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PW; i++) begin
      if (i < int'(sel)) mask[i] = 1'b1;
    end
  end

  assign tick = run && !restart && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (restart) pcnt_q <= '0;
    else if (run)     pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          svc,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] delta,
  output logic [CW-1:0] cnt,
  output wdg_pkg::cause_t cause,
  output logic          rst_req
);
  logic [CW-1:0] cnt_q;

  assign cause.uflow = en && !svc && tick && (cnt_q == '0);
  assign cause.early = en && svc && (cnt_q > delta);
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= cause.uflow || cause.early;
      if (!en || svc)   cnt_q <= reload;
      else if (tick)    cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int          CW    = 12,
  parameter int          SEL_W = 3,
  parameter logic [15:0] KEY   = 16'h3C96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [CW-1:0]    cnt,
  input  cause_t           cause,
  output logic [CW-1:0]    reload,
  output logic [CW-1:0]    delta,
  output logic [SEL_W-1:0] sel,
  output logic             en,
  output logic             dbg_stop,
  output logic             locked,
  output logic             svc
);
  cause_t stat_q;
  logic   cfg_wr;

  assign cfg_wr = wr_en && !locked;
  assign svc    = wr_en && (wr_addr == A_SVC) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload   <= '1;
      delta    <= '1;
      sel      <= '0;
      en       <= 1'b0;
      dbg_stop <= 1'b0;
      locked   <= 1'b1;
      stat_q   <= '0;
    end else begin
      if (wr_en && wr_addr == A_KEY) locked <= (wr_data != KEY);
      if (cfg_wr && wr_addr == A_RELOAD) reload <= wr_data[CW-1:0];
      if (cfg_wr && wr_addr == A_DELTA)  delta  <= wr_data[CW-1:0];
      if (cfg_wr && wr_addr == A_CTRL) begin
        en       <= en | wr_data[0];
        dbg_stop <= wr_data[1];
        sel      <= wr_data[2 +: SEL_W];
      end
      stat_q <= ((rd_en && rd_addr == A_STAT) ? cause_t'(2'b00) : stat_q) | cause;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_RELOAD: rd_data = DW'(reload);
      A_DELTA:  rd_data = DW'(delta);
      A_CTRL:   rd_data = DW'({sel, dbg_stop, en});
      A_KEY:    rd_data = DW'(locked);
      A_STAT:   rd_data = DW'(stat_q);
      A_COUNT:  rd_data = DW'(cnt);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int          CW    = 12,
  parameter int          SEL_W = 3,
  parameter logic [15:0] KEY   = 16'h3C96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          dbg_halt,
  output logic          rst_req
);
  logic [CW-1:0]    reload, delta, cnt;
  logic [SEL_W-1:0] sel;
  logic             en, dbg_stop, locked, svc, tick, run;
  cause_t           cause;

  assign run = en && !(dbg_halt && dbg_stop);

  wdg_regs #(.CW(CW), .SEL_W(SEL_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt), .cause(cause),
    .reload(reload), .delta(delta), .sel(sel), .en(en), .dbg_stop(dbg_stop),
    .locked(locked), .svc(svc)
  );

  wdg_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(svc || !en), .sel(sel), .tick(tick)
  );

  wdg_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .svc(svc), .reload(reload),
    .delta(delta), .cnt(cnt), .cause(cause), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          tick,
  input logic          svc,
  input logic          locked,
  input logic          dbg_halt,
  input logic          dbg_stop,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] reload,
  input logic [CW-1:0] delta,
  input logic          rst_req
);
  // R2
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && tick && !svc && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
  // R3
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && tick && !svc && cnt == '0 |=> rst_req && cnt == $past(reload));
  // R4
  early_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && svc && cnt > delta |=> rst_req && cnt == $past(reload));
  // R5
  legal_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && svc && cnt <= delta |=> !rst_req && cnt == $past(reload));
  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && dbg_halt && dbg_stop && !svc |=> $stable(cnt) && !rst_req);
  // R7
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_en && wr_addr <= 3'd2 |=> $stable(reload) && $stable(delta) && $stable(en));
  // R8
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
endmodule

bind win_watchdog wdg_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .svc(svc), .locked(locked),
  .dbg_halt(dbg_halt), .dbg_stop(dbg_stop), .wr_en(wr_en), .wr_addr(wr_addr),
  .cnt(cnt), .reload(reload), .delta(delta), .rst_req(rst_req)
);

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, dbg_halt = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rst_req;
  int          n_run = 0, n_fail = 0;

  localparam logic [15:0] KEY = 16'h3C96;

  win_watchdog dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt(dbg_halt),
    .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #2 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = int'(rd_data);
    @(posedge clk);
    #2 rd_en = 1'b0;
  endtask

  task automatic service();
    wr(3'd4, 16'h0001);
  endtask

  task automatic edges_to_req(input int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk);
      #2;
      if (rst_req && k < 0) begin k = i; break; end
    end
  endtask

  task automatic t_reset();
    int v;
    check("R1 rst_req", int'(rst_req), 0);
    rd(3'd3, v); check("R1 lock", v, 1);
    rd(3'd0, v); check("R1 reload", v, 'hFFF);
    rd(3'd1, v); check("R1 delta", v, 'hFFF);
    rd(3'd2, v); check("R1 ctrl", v, 0);
    rd(3'd5, v); check("R1 status", v, 0);
  endtask

  task automatic t_lock();
    int v;
    wr(3'd0, 16'h0123);
    rd(3'd0, v); check("R7 locked reload write ignored", v, 'hFFF);
    wr(3'd3, KEY);
    rd(3'd3, v); check("R7 key unlocks", v, 0);
    wr(3'd0, 16'h0123);
    rd(3'd0, v); check("R7 unlocked write", v, 'h123);
    wr(3'd3, 16'h0001);
    rd(3'd3, v); check("R7 wrong key relocks", v, 1);
    wr(3'd1, 16'h0050);
    rd(3'd1, v); check("R7 locked delta write ignored", v, 'hFFF);
    wr(3'd3, KEY);
  endtask

  task automatic t_underflow_div1();
    int k, v;
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h0001);
    edges_to_req(50, k); check("R3 underflow edge sel0", k, 6);
    @(posedge clk); #2 check("R3 one-cycle pulse", int'(rst_req), 0);
    wr(3'd0, 16'd400);
    service();
    rd(3'd5, v); check("R3 status uflow bit", v, 1);
    rd(3'd5, v); check("R9 status cleared by read", v, 0);
  endtask

  task automatic t_underflow_div4();
    int k, v;
    wr(3'd0, 16'd3);
    wr(3'd2, 16'h0009);
    service();
    edges_to_req(200, k); check("R2 underflow edge sel2", k, 16);
    wr(3'd0, 16'd400);
    service();
    rd(3'd5, v); check("R3 status after sel2 underflow", v, 1);
  endtask

  task automatic t_early();
    int v;
    wr(3'd1, 16'd100);
    service();
    check("R4 early service request", int'(rst_req), 1);
    rd(3'd6, v); check("R4 count reloaded after fault", v, 400);
    rd(3'd5, v); check("R4 status early bit", v, 2);
  endtask

  task automatic t_window_edge();
    int v;
    wr(3'd2, 16'h0001);
    service();
    repeat (299) @(posedge clk);
    service();
    check("R4 count 101 above threshold", int'(rst_req), 1);
    repeat (300) @(posedge clk);
    service();
    check("R5 count equal to threshold legal", int'(rst_req), 0);
    rd(3'd6, v); check("R5 count restored", v, 400);
    rd(3'd5, v); check("R9 status holds early", v, 2);
    rd(3'd5, v); check("R9 status cleared", v, 0);
  endtask

  task automatic t_freeze();
    int v, hits;
    hits = 0;
    wr(3'd1, 16'hFFF);
    wr(3'd2, 16'h0003);
    service();
    dbg_halt = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk); #2 if (rst_req) hits++;
    end
    check("R6 no request while frozen", hits, 0);
    rd(3'd6, v); check("R6 count held", v, 400);
    @(negedge clk); dbg_halt = 1'b0;
    service();
  endtask

  task automatic t_sticky_en();
    int v;
    wr(3'd2, 16'h0000);
    rd(3'd2, v); check("R8 enable stays set", v & 1, 1);
    repeat (5) @(posedge clk);
    rd(3'd6, v); check("R8 still counting", int'(v < 400), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_lock();
    t_underflow_div1();
    t_underflow_div4();
    t_early();
    t_window_edge();
    t_freeze();
    t_sticky_en();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule